// File: doc/BRIEF.md
# Bus Clock Prescaler Tree

This block turns one system clock into three rate enables for a bus hierarchy. The first divider produces a high-speed bus tick from the system clock. Two peripheral bus dividers count those high-speed ticks, not system clock cycles. Every output is a single-cycle pulse in the system clock domain, and downstream logic uses it as a clock enable.

Each ratio comes from a small code field that selects a power of two. The high-speed field has four bits. Its upper half maps to the ratios 2, 4, 8, 16, 64, 128, 256 and 512, so there is no divide-by-32. Each peripheral field has three bits, and its upper half maps to 2, 4, 8 and 16. A new code never cuts short a period already in progress. Each divider takes its new ratio at its own next tick.

Top module: `busclk_tree`

## Requirements
- R1: While `rst_n` is low, the divider state is undivided. In the sample after the last reset edge, all three ticks are high.
- R2: An `ahb_code` with bit 3 = 0 makes `ahb_tick` high in every cycle, whatever the value of bits 2:0.
- R3: `ahb_code` 4'b1000, 4'b1001, 4'b1010 and 4'b1011 make `ahb_tick` a one-cycle pulse every 2, 4, 8 and 16 system cycles. The first pulse comes in the cycle that leaves reset.
- R4: `ahb_code` 4'b1100, 4'b1101, 4'b1110 and 4'b1111 give a period of 64, 128, 256 and 512 system cycles.
- R5: An APB code with bit 2 = 0 makes that APB tick fire on every `ahb_tick`.
- R6: APB codes 3'b100, 3'b101, 3'b110 and 3'b111 make that APB tick fire on every 2nd, 4th, 8th and 16th `ahb_tick`. The first one fires on the first `ahb_tick` after reset.
- R7: `apb1_tick` and `apb2_tick` are high only in cycles where `ahb_tick` is high.
- R8: A code change takes effect only after that divider's next tick. The period running when the change arrives completes at its old length.
- R9: The two APB dividers are independent. Each follows only its own code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ahb_code | input | 4 | High-speed bus ratio code |
| apb1_code | input | 3 | First peripheral bus ratio code |
| apb2_code | input | 3 | Second peripheral bus ratio code |
| ahb_tick | output | 1 | High-speed bus enable pulse |
| apb1_tick | output | 1 | First peripheral bus enable pulse |
| apb2_tick | output | 1 | Second peripheral bus enable pulse |

## Verification
The hardest situation to reach is a ratio code that changes partway through a period. A faulty design would shorten or stretch that period, and the fault only shows if the change lands between ticks. The driver releases reset with a known code and counts falling edges from the release. It then rewrites the code at a chosen sample index between two scheduled ticks. The expected schedule finishes the running period at its old length before switching to the new one. The widest cascade is exercised separately: divide-by-512 feeding a further divide-by-2, so peripheral ticks come 1024 system cycles apart.

// File: rtl/busclk_pkg.sv
// Package: shared sizing helpers for the prescaler tree.
// Assumes: a code field splits into one enable bit and a lower index field.
package busclk_pkg;

    // Largest log2 ratio a code field can select.
    function automatic int max_shift(input int code_w, input int has_gap);
        return (1 << (code_w - 1)) + has_gap;
    endfunction

    // Bits needed to hold a shift value in 0..max.
    function automatic int shift_width(input int max_sh);
        return $clog2(max_sh + 1);
    endfunction

endpackage

// File: rtl/busclk_decode.sv
// Module: maps a ratio code to log2 of the division ratio.
// The top code bit enables division. The lower bits select 2^(idx+1).
// With HAS_GAP set, the upper half of the index range skips one power
// of two.
// Assumes: CODE_W >= 2 and SH_W wide enough for the largest shift.
module busclk_decode #(
    parameter int CODE_W  = 4,
    parameter int HAS_GAP = 1,
    parameter int SH_W    = 4
) (
    input  logic [CODE_W-1:0] code,
    output logic [SH_W-1:0]   shift
);
    localparam int IDX_W = CODE_W - 1;

    logic [IDX_W-1:0] idx;
    logic [SH_W-1:0]  skip;

    assign idx = code[IDX_W-1:0];

    generate
        if (HAS_GAP != 0) begin : g_gap
            // Upper half of the index range jumps one extra power of two.
            assign skip = SH_W'(idx[IDX_W-1]);
        end else begin : g_nogap
            assign skip = '0;
        end
    endgenerate

    // Enabled codes give idx+1 (+skip); disabled codes give no division.
    always_comb begin
        if (code[CODE_W-1]) shift = SH_W'(idx) + SH_W'(1) + skip;
        else                shift = '0;
    end

endmodule

// File: rtl/busclk_div.sv
// Module: a free-running power-of-two divider clocked by an enable.
// It counts src_en pulses and raises tick on the last count of each
// period. The ratio is reloaded from next_shift only when tick fires.
// Assumes: next_shift <= MAX_SH, and src_en is synchronous to clk.
module busclk_div #(
    parameter int MAX_SH = 9,
    parameter int SH_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            src_en,
    input  logic [SH_W-1:0] next_shift,
    output logic            tick
);
    localparam int CNT_W = (MAX_SH > 0) ? MAX_SH : 1;

    logic [CNT_W-1:0] cnt;
    logic [SH_W-1:0]  cur_shift;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   span_m1;
    logic [CNT_W-1:0] last;

    // Last count value of the running period: 2^cur_shift - 1.
    always_comb begin
        span    = (CNT_W + 1)'(1) << cur_shift;
        span_m1 = span - (CNT_W + 1)'(1);
        last    = span_m1[CNT_W-1:0];
    end

    assign tick = src_en && (cnt == last);

    // Advance on each source enable; wrap and reload the ratio on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            cur_shift <= '0;
        end else if (src_en) begin
            if (cnt == last) begin
                cnt       <= '0;
                cur_shift <= next_shift;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    p_tick_has_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> src_en);
    p_count_in_span_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last);
    p_shift_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cur_shift));
    p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == '0));
    p_shift_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cur_shift) <= MAX_SH);

endmodule

// File: rtl/busclk_tree.sv
// Module: a three-divider prescaler tree.
// The high-speed divider runs from the system clock. Both peripheral
// dividers advance only on high-speed ticks.
// Assumes: codes are synchronous to clk; all ticks are enables, not clocks.
module busclk_tree #(
    parameter int AHB_CODE_W = 4,
    parameter int APB_CODE_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AHB_CODE_W-1:0] ahb_code,
    input  logic [APB_CODE_W-1:0] apb1_code,
    input  logic [APB_CODE_W-1:0] apb2_code,
    output logic                  ahb_tick,
    output logic                  apb1_tick,
    output logic                  apb2_tick
);
    import busclk_pkg::*;

    localparam int AHB_MAX = max_shift(AHB_CODE_W, 1);
    localparam int APB_MAX = max_shift(APB_CODE_W, 0);
    localparam int AHB_SHW = shift_width(AHB_MAX);
    localparam int APB_SHW = shift_width(APB_MAX);
    localparam int N_APB   = 2;

    logic [AHB_SHW-1:0]    ahb_shift;
    logic [APB_CODE_W-1:0] apb_code [N_APB];
    logic [N_APB-1:0]      apb_tick;

    assign apb_code[0] = apb1_code;
    assign apb_code[1] = apb2_code;
    assign apb1_tick   = apb_tick[0];
    assign apb2_tick   = apb_tick[1];

    busclk_decode #(.CODE_W(AHB_CODE_W), .HAS_GAP(1), .SH_W(AHB_SHW)) u_ahb_dec (
        .code  (ahb_code),
        .shift (ahb_shift)
    );

    busclk_div #(.MAX_SH(AHB_MAX), .SH_W(AHB_SHW)) u_ahb_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_en     (1'b1),
        .next_shift (ahb_shift),
        .tick       (ahb_tick)
    );

    generate
        for (genvar g = 0; g < N_APB; g++) begin : g_apb
            logic [APB_SHW-1:0] sh;

            busclk_decode #(.CODE_W(APB_CODE_W), .HAS_GAP(0), .SH_W(APB_SHW)) u_dec (
                .code  (apb_code[g]),
                .shift (sh)
            );

            busclk_div #(.MAX_SH(APB_MAX), .SH_W(APB_SHW)) u_div (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_en     (ahb_tick),
                .next_shift (sh),
                .tick       (apb_tick[g])
            );
        end
    endgenerate

    p_apb1_within_ahb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apb1_tick |-> ahb_tick);
    p_apb2_within_ahb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        apb2_tick |-> ahb_tick);

endmodule

// File: tb/busclk_tree_bench.sv
// Scoreboard bench: the driver queues expected tick triples; the monitor
// pops one per cycle and compares.
module busclk_tree_bench;

    typedef struct {
        bit    a;
        bit    p1;
        bit    p2;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ahb_code = 4'b0;
    logic [2:0] apb1_code = 3'b0;
    logic [2:0] apb2_code = 3'b0;
    logic       ahb_tick, apb1_tick, apb2_tick;

    exp_t q[$];
    int   n_chk  = 0;
    int   n_fail = 0;

    always #5 clk = ~clk;

    busclk_tree u_busclk_tree (
        .clk       (clk),
        .rst_n     (rst_n),
        .ahb_code  (ahb_code),
        .apb1_code (apb1_code),
        .apb2_code (apb2_code),
        .ahb_tick  (ahb_tick),
        .apb1_tick (apb1_tick),
        .apb2_tick (apb2_tick)
    );

    // Ratio tables taken from R2..R6.
    function automatic int ahb_ratio(input logic [3:0] c);
        if (!c[3]) return 1;
        return c[2] ? (64 << c[1:0]) : (2 << c[1:0]);
    endfunction

    function automatic int apb_ratio(input logic [2:0] c);
        if (!c[2]) return 1;
        return 2 << c[1:0];
    endfunction

    // Run one case. If chg_at > 0, ahb_code becomes new_ahb after sample chg_at.
    task automatic run_case(input logic [3:0] a, input logic [2:0] b1,
                            input logic [2:0] b2, input int chg_at,
                            input logic [3:0] new_ahb, input int len,
                            input string tag);
        int next_a = 0;
        int k = 0;
        int m1 = apb_ratio(b1);
        int m2 = apb_ratio(b2);
        @(negedge clk);
        rst_n = 1'b0;
        ahb_code = a; apb1_code = b1; apb2_code = b2;
        @(negedge clk);
        @(negedge clk);
        for (int i = 0; i < len; i++) begin
            exp_t e;
            e.a = (i == next_a);
            e.p1 = e.a && (k % m1 == 0);
            e.p2 = e.a && (k % m2 == 0);
            e.tag = (i == 0) ? "R1" : tag;
            if (e.a) begin
                next_a = i + (((chg_at > 0) && (i >= chg_at)) ? ahb_ratio(new_ahb)
                                                              : ahb_ratio(a));
                k++;
            end
            q.push_back(e);
        end
        @(negedge clk);
        rst_n = 1'b1;
        if (chg_at > 0) begin
            repeat (chg_at) @(negedge clk);
            ahb_code = new_ahb;
        end
        while (q.size() != 0) @(negedge clk);
    endtask

    // Monitor: one comparison per cycle, away from the clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #3;
            if (q.size() != 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if ({ahb_tick, apb1_tick, apb2_tick} !== {e.a, e.p1, e.p2}) begin
                    n_fail++;
                    $display("FAIL %s: ticks got %b%b%b expected %b%b%b", e.tag,
                             ahb_tick, apb1_tick, apb2_tick, e.a, e.p1, e.p2);
                end
                n_chk++;   // R7: no APB tick without an AHB tick
                if ((apb1_tick || apb2_tick) && !ahb_tick) begin
                    n_fail++;
                    $display("FAIL R7: apb ticks %b%b got with ahb %b expected ahb 1",
                             apb1_tick, apb2_tick, ahb_tick);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: run got no end expected end before timeout");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        run_case(4'b0000, 3'b000, 3'b000, 0, 4'b0, 8,    "R2");
        run_case(4'b0111, 3'b011, 3'b010, 0, 4'b0, 8,    "R2_R5");
        run_case(4'b1000, 3'b100, 3'b101, 0, 4'b0, 20,   "R3_R6_R9");
        run_case(4'b1001, 3'b110, 3'b111, 0, 4'b0, 130,  "R3_R6");
        run_case(4'b1010, 3'b000, 3'b100, 0, 4'b0, 40,   "R3_R5_R9");
        run_case(4'b1011, 3'b101, 3'b000, 0, 4'b0, 140,  "R3_R6");
        run_case(4'b1100, 3'b100, 3'b000, 0, 4'b0, 260,  "R4");
        run_case(4'b1101, 3'b000, 3'b000, 0, 4'b0, 260,  "R4");
        run_case(4'b1110, 3'b000, 3'b101, 0, 4'b0, 1030, "R4_R6");
        run_case(4'b1111, 3'b100, 3'b000, 0, 4'b0, 2050, "R4_R6");
        run_case(4'b1001, 3'b000, 3'b000, 6, 4'b1000, 20, "R8");
        run_case(4'b1000, 3'b000, 3'b100, 3, 4'b1011, 40, "R8");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule